// File: doc/BRIEF.md
# PWM Time Base Timer

This block is the counting engine that sits underneath a PWM unit. A 12-bit counter advances once per prescaled tick of the system clock and is compared against a programmable period value. Three counting schemes are available:

- **Free-running up-count**: the counter wraps back to zero after the period value.
- **Single-shot**: the counter makes one pass up to the period and then switches itself off.
- **Continuous up/down**: the counter climbs to the period and then descends back to zero.

Each period event can raise an interrupt. In the repeating modes a postscaler thins these events. Every interrupt produces a one-cycle request pulse, which is followed by a flag that stays set until software clears it.

Software drives a flat set of control inputs: set and clear strobes for the run bit, a two-bit mode code, the period value, a prescaler select and a postscaler select. It reads back the live count, the current count direction, the run status, the interrupt pulse and the sticky flag. Neither the duty-cycle compare logic nor the PWM output stage belongs to this block.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low, and after it is released, `count` is 0, `count_down` is 0, and `run_status`, `irq_pulse` and `irq_flag` are all 0.
- R2: `pre_sel` values 0, 1, 2 and 3 make the counter advance once every 1, 4, 16 and 64 clocks respectively. The first advance comes that many clocks after the run bit is set. The prescale divider restarts from zero whenever the run bit is low.
- R3: `mode` = 00 selects free-running up-count. On each tick the count goes up by one. If the count on a tick is already greater than or equal to `period`, the count instead goes to 0 and an event is raised. The count is 12 bits wide, so a period of 4095 gives 4096 ticks per event.
- R4: `mode` = 01 selects single-shot. On the tick where the count is greater than or equal to `period`, three things happen: the count goes to 0, an event is raised, and the run bit is cleared. The postscaler is ignored, so that event always produces a pulse.
- R5: `mode` = 10 and `mode` = 11 select up/down counting. While the count is below `period` it goes up; once it reaches `period` it reverses downward. When a downward step brings it to 0, it turns upward again and raises an event. With `period` = 0 the count holds at 0 and raises no events.
- R6: In modes 00, 10 and 11, `post_sel` = k passes only every (k+1)-th event, for ratios 1:1 through 1:16. The event count restarts from zero whenever the run bit is low.
- R7: A high `en_set` sets the run bit and takes priority over both `en_clr` and the single-shot clear. A high `en_clr` clears the run bit. `run_status` shows the run bit. While it is low, `count` and `count_down` hold their values.
- R8: `irq_pulse` is high for the one clock in which the count takes the value produced by a passed event. `irq_flag` rises on the following clock and stays high until `flag_clr` is applied. If a pulse and `flag_clr` coincide, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | 1 | Sets the run bit |
| en_clr | input | 1 | Clears the run bit |
| mode | input | 2 | 00 free, 01 single-shot, 10/11 up/down |
| period | input | 12 | Period value |
| pre_sel | input | 2 | Prescale select: 1, 4, 16 or 64 |
| post_sel | input | 4 | Postscale ratio minus one |
| flag_clr | input | 1 | Clears the sticky flag |
| count | output | 12 | Current count |
| count_down | output | 1 | 1 while counting downward |
| irq_pulse | output | 1 | One-clock interrupt request |
| irq_flag | output | 1 | Sticky interrupt flag |
| run_status | output | 1 | Current run bit |

## Verification
The bench targets the full 4095 period, a zero period in every mode, and a period lowered below the live count. A design with an equality-only match would never wrap in the last of these, and an off-by-one match would be exposed at the 4095 period. It checks that single-shot drops the run bit and ignores a nonzero postscale; a design that got this wrong would keep counting or swallow the pulse. It also checks that the postscale count restarts after a disable, since stale state would fire early. Finally it checks the one-clock flag lag and that a pulse beats a simultaneous clear; a design wrong here would set the flag early or lose an interrupt.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;
    typedef enum logic [1:0] {
        TB_FREE     = 2'b00,
        TB_ONCE     = 2'b01,
        TB_UPDN     = 2'b10,
        TB_UPDN_DBL = 2'b11
    } tb_mode_e;
endpackage

// File: rtl/ptb_prescaler.sv
`timescale 1ns/1ps
module ptb_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    // divide ratio is 4**sel, so the widest divider needs 2*(2**SEL_W - 1) bits
    localparam int CW = 2 * ((1 << SEL_W) - 1);
    localparam logic [CW-1:0] C_ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t     st_d, st_q;
    logic [CW:0] span;
    logic [CW-1:0] lim;

    always_comb begin
        span = '0;
        span[2 * sel] = 1'b1;
        lim  = span[CW-1:0] - C_ONE;
        tick = run && (st_q.cnt == lim);
        st_d = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + C_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ptb_counter.sv
`timescale 1ns/1ps
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             down,
    output logic             evt,
    output logic             once_done
);
    localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_st_t;

    cnt_st_t  st_d, st_q;
    tb_mode_e mode_e;

    always_comb begin
        mode_e    = tb_mode_e'(mode);
        st_d      = st_q;
        evt       = 1'b0;
        once_done = 1'b0;
        if (tick) begin
            case (mode_e)
                TB_FREE, TB_ONCE: begin
                    st_d.down = 1'b0;
                    if (st_q.cnt >= period) begin
                        st_d.cnt  = '0;
                        evt       = 1'b1;
                        once_done = (mode_e == TB_ONCE);
                    end else begin
                        st_d.cnt = st_q.cnt + C_ONE;
                    end
                end
                default: begin
                    if (period == '0) begin
                        st_d.cnt  = '0;
                        st_d.down = 1'b0;
                    end else if (!st_q.down) begin
                        if (st_q.cnt >= period) begin
                            st_d.down = 1'b1;
                            st_d.cnt  = st_q.cnt - C_ONE;
                        end else begin
                            st_d.cnt = st_q.cnt + C_ONE;
                        end
                    end else if (st_q.cnt <= C_ONE) begin
                        st_d.cnt  = '0;
                        st_d.down = 1'b0;
                        evt       = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - C_ONE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign down  = st_q.down;
endmodule

// File: rtl/ptb_postscaler.sv
`timescale 1ns/1ps
module ptb_postscaler #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              evt,
    input  logic              bypass,
    input  logic [POST_W-1:0] ratio,
    output logic              fire
);
    localparam logic [POST_W-1:0] C_ONE = {{(POST_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [POST_W-1:0] cnt;
    } post_st_t;

    post_st_t st_d, st_q;

    always_comb begin
        fire = evt && (bypass || (st_q.cnt == ratio));
        st_d = st_q;
        if (!run || fire) begin
            st_d.cnt = '0;
        end else if (evt) begin
            st_d.cnt = st_q.cnt + C_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int PRE_W  = 2,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  period,
    input  logic [PRE_W-1:0]  pre_sel,
    input  logic [POST_W-1:0] post_sel,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  count,
    output logic              count_down,
    output logic              irq_pulse,
    output logic              irq_flag,
    output logic              run_status
);
    typedef struct packed {
        logic run;
        logic pulse;
        logic flag;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    tick;
    logic    evt;
    logic    once_done;
    logic    fire;
    logic    bypass;

    ptb_prescaler #(.SEL_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.run),
        .sel   (pre_sel),
        .tick  (tick)
    );

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .period    (period),
        .count     (count),
        .down      (count_down),
        .evt       (evt),
        .once_done (once_done)
    );

    assign bypass = (tb_mode_e'(mode) == TB_ONCE);

    ptb_postscaler #(.POST_W(POST_W)) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.run),
        .evt    (evt),
        .bypass (bypass),
        .ratio  (post_sel),
        .fire   (fire)
    );

    always_comb begin
        st_d = st_q;
        if (en_set) begin
            st_d.run = 1'b1;
        end else if (en_clr || once_done) begin
            st_d.run = 1'b0;
        end
        st_d.pulse = fire;
        if (st_q.pulse) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pulse  = st_q.pulse;
    assign irq_flag   = st_q.flag;
    assign run_status = st_q.run;
endmodule

// File: rtl/ptb_checks.sv
`timescale 1ns/1ps
module ptb_checks #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_set,
    input logic [1:0]       mode,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             count_down,
    input logic             irq_pulse,
    input logic             irq_flag,
    input logic             run_status
);
    a_r8_flag_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> irq_flag);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    a_r8_flag_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(irq_pulse));

    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_status |=> ($stable(count) && $stable(count_down)));

    a_r4_once_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(mode) == 2'b01 && !$past(en_set))
            |-> (count == '0 && !run_status));

    a_r3_free_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(mode) == 2'b00) |-> (count == '0));

    a_r5_turn_up: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(mode[1])) |-> (count == '0 && !count_down));
endmodule

bind pwm_timebase ptb_checks #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_set     (en_set),
    .mode       (mode),
    .flag_clr   (flag_clr),
    .count      (count),
    .count_down (count_down),
    .irq_pulse  (irq_pulse),
    .irq_flag   (irq_flag),
    .run_status (run_status)
);

// File: tb/pwm_timebase_tb.sv
`timescale 1ns/1ps
module pwm_timebase_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_set, en_clr, flag_clr;
    logic [1:0]  mode;
    logic [11:0] period;
    logic [1:0]  pre_sel;
    logic [3:0]  post_sel;
    logic [11:0] count;
    logic        count_down, irq_pulse, irq_flag, run_status;

    int total = 0;
    int bad   = 0;
    int pulses;

    always #4 clk = ~clk;

    pwm_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .mode(mode), .period(period), .pre_sel(pre_sel), .post_sel(post_sel),
        .flag_clr(flag_clr), .count(count), .count_down(count_down),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag), .run_status(run_status)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [11:0] per;
        logic [1:0]  pre;
        logic [3:0]  post;
        logic [15:0] ncyc;
        logic [7:0]  npulse;
        logic [11:0] cnt;
        logic        run;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 12'd4,    2'd0, 4'd0, 16'd12,   8'd2, 12'd2, 1'b1}, // R3
        '{2'd0, 12'd4,    2'd1, 4'd0, 16'd48,   8'd2, 12'd2, 1'b1}, // R2 1:4
        '{2'd0, 12'd2,    2'd0, 4'd1, 16'd20,   8'd3, 12'd2, 1'b1}, // R6 1:2
        '{2'd1, 12'd3,    2'd0, 4'd3, 16'd10,   8'd1, 12'd0, 1'b0}, // R4 postscale ignored
        '{2'd2, 12'd3,    2'd0, 4'd0, 16'd14,   8'd2, 12'd2, 1'b1}, // R5
        '{2'd3, 12'd3,    2'd0, 4'd1, 16'd18,   8'd1, 12'd0, 1'b1}, // R5 R6
        '{2'd1, 12'd4,    2'd1, 4'd0, 16'd30,   8'd1, 12'd0, 1'b0}, // R4 R2
        '{2'd2, 12'd0,    2'd0, 4'd0, 16'd10,   8'd0, 12'd0, 1'b1}, // R5 zero period
        '{2'd0, 12'd0,    2'd0, 4'd0, 16'd5,    8'd5, 12'd0, 1'b1}, // R3 zero period
        '{2'd0, 12'd1,    2'd2, 4'd0, 16'd64,   8'd2, 12'd0, 1'b1}, // R2 1:16
        '{2'd0, 12'd0,    2'd3, 4'd0, 16'd128,  8'd2, 12'd0, 1'b1}, // R2 1:64
        '{2'd0, 12'd4095, 2'd0, 4'd0, 16'd4098, 8'd1, 12'd2, 1'b1}  // R3 full width
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en_set = 1'b0; en_clr = 1'b0; flag_clr = 1'b0;
        mode = 2'd0; period = 12'd0; pre_sel = 2'd0; post_sel = 4'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step_count();
        @(posedge clk);
        @(negedge clk);
        if (irq_pulse) pulses++;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(count == 12'd0, "R1 count", int'(count), 0);
        chk(!count_down, "R1 direction", int'(count_down), 0);
        chk(!run_status, "R1 run", int'(run_status), 0);
        chk(!irq_pulse && !irq_flag, "R1 irq", int'({irq_pulse, irq_flag}), 0);

        // table walk: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            do_reset();
            mode = VECS[v].md; period = VECS[v].per;
            pre_sel = VECS[v].pre; post_sel = VECS[v].post;
            en_set = 1'b1;
            @(posedge clk);
            @(negedge clk);
            en_set = 1'b0;
            pulses = 0;
            for (int c = 0; c < int'(VECS[v].ncyc); c++) step_count();
            chk(pulses == int'(VECS[v].npulse), $sformatf("R3/R4/R5/R6 pulses vec %0d", v),
                pulses, int'(VECS[v].npulse));
            chk(count == VECS[v].cnt, $sformatf("R2/R3/R5 count vec %0d", v),
                int'(count), int'(VECS[v].cnt));
            chk(run_status == VECS[v].run, $sformatf("R4/R7 run vec %0d", v),
                int'(run_status), int'(VECS[v].run));
            chk(irq_flag == (pulses > 0), $sformatf("R8 flag vec %0d", v),
                int'(irq_flag), int'(pulses > 0));
        end

        // R8 flag timing, clear, and set-over-clear
        do_reset();
        period = 12'd1; en_set = 1'b1;
        @(posedge clk); @(negedge clk); en_set = 1'b0;
        @(posedge clk); @(negedge clk);          // E1: count 1
        @(posedge clk); @(negedge clk);          // E2: pulse
        chk(irq_pulse && !irq_flag, "R8 flag lags pulse", int'({irq_pulse, irq_flag}), 2);
        @(posedge clk); @(negedge clk);          // E3
        chk(irq_flag && !irq_pulse, "R8 flag set", int'({irq_pulse, irq_flag}), 1);
        flag_clr = 1'b1;
        @(posedge clk); @(negedge clk);          // E4: cleared, new pulse
        chk(!irq_flag && irq_pulse, "R8 flag cleared", int'({irq_pulse, irq_flag}), 2);
        @(posedge clk); @(negedge clk);          // E5: set beats clear
        chk(irq_flag, "R8 set wins over clear", int'(irq_flag), 1);
        @(posedge clk); @(negedge clk);          // E6
        chk(!irq_flag, "R8 clear without pulse", int'(irq_flag), 0);
        flag_clr = 1'b0;

        // R7 hold while disabled, set beats clear; R3 period lowered below count
        do_reset();
        period = 12'd10; en_set = 1'b1;
        @(posedge clk); @(negedge clk); en_set = 1'b0;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk(count == 12'd3, "R7 pre-disable count", int'(count), 3);
        en_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        en_clr = 1'b0;
        repeat (5) begin @(posedge clk); @(negedge clk); end
        chk(count == 12'd4 && !run_status, "R7 held while off", int'(count), 4);
        en_set = 1'b1; en_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        en_set = 1'b0; en_clr = 1'b0;
        chk(run_status, "R7 set beats clear", int'(run_status), 1);
        period = 12'd2;
        @(posedge clk); @(negedge clk);
        chk(count == 12'd0 && irq_pulse, "R3 wrap when count above period", int'(count), 0);

        // R6 postscale count restarts after disable
        do_reset();
        period = 12'd0; post_sel = 4'd3; en_set = 1'b1;
        @(posedge clk); @(negedge clk); en_set = 1'b0;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        en_clr = 1'b1;
        @(posedge clk); @(negedge clk); en_clr = 1'b0;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        en_set = 1'b1;
        @(posedge clk); @(negedge clk); en_set = 1'b0;
        pulses = 0;
        step_count();
        chk(pulses == 0, "R6 no early fire after restart", pulses, 0);
        step_count(); step_count(); step_count();
        chk(pulses == 1 && irq_pulse, "R6 fires on fourth event", pulses, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule